// File: doc/BRIEF.md
# Complementary PWM Driver with Programmable Dead Band

This block drives a half-bridge with two pulse-width outputs, a high-side drive and a low-side drive, from one 12-bit setting. A free-running counter steps through a period of 255 clock cycles, and an 8-bit duty value is compared against it to form a raw pulse. The high side follows the raw pulse and the low side follows its complement. At every switching edge, the output that is about to turn on is held off for a programmed number of clock cycles, from 0 to 15. The output that is turning off drops at once.

The setting comes from one of two sources. The first is a register written over a valid/ready write channel, where a field strobe selects which parts of the word a write updates. The second is a set of twelve static pins, one per control bit. A select pin picks the source. Whichever source is active, the counter logic copies the setting into shadow copies only at the first cycle of each period, so a change never cuts a pulse short in the middle of a period.

Top module: `cpwm_top`

## Requirements
- R1: The period is 255 cycles, with the counter running 0 to 254. With dead time 0, drv_hi is high for exactly `duty` cycles per period, starting at the period's first cycle.
- R2: A duty of 255 keeps drv_hi high for the whole period. A duty of 0 keeps drv_hi low and drv_lo high for the whole period, once steady.
- R3: After the raw pulse rises, drv_hi stays low for `dead` cycles and then rises. It rises on the same cycle as the raw pulse when dead is 0. In steady state drv_hi is high for duty−dead cycles.
- R4: drv_lo is the complement of the raw pulse with the same turn-on delay, so it is high for (255−duty)−dead cycles per period. The output that is turning off falls on the cycle of the raw edge.
- R5: drv_hi and drv_lo are never high on the same cycle.
- R6: When a phase is no longer than the dead time, the output for that phase stays low for the whole phase.
- R7: A new setting takes effect only at the start of the next period. A write in mid-period leaves the current period's pulse unchanged.
- R8: The word layout is bits [7:0] = duty and bits [11:8] = dead. wr_field[0] updates the duty field and wr_field[1] updates the dead field. A write with a field strobe low leaves that field unchanged, and a write with both strobes low changes nothing.
- R9: With src_sel=1 the setting comes from pin_bits, using the same layout. Register writes made meanwhile have no effect on the outputs.
- R10: A synchronous active-high rst clears the register to zero and holds both outputs low while it is asserted.
- R11: wr_ready is always high. A write is accepted on each clock edge at which wr_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write acceptance, always high |
| wr_field | input | 2 | Field strobes: bit 0 duty, bit 1 dead |
| wr_data | input | 12 | Write word: [7:0] duty, [11:8] dead |
| src_sel | input | 1 | 0 = register source, 1 = pin source |
| pin_bits | input | 12 | Static per-bit setting, same layout as wr_data |
| drv_hi | output | 1 | High-side drive, active high |
| drv_lo | output | 1 | Low-side drive, active high |

## Verification
The assertions assume that rst is high for at least one clock edge before any property is meaningful. They also assume that pin_bits and wr_data are sampled only at clock edges, so that the shadow copies change only as the counter wraps to zero. The stimulus asserts reset first and drives every input at the falling clock edge. It judges steady-state pulse widths only on the third period after a setting changes, so that history carried over from the previous setting cannot blur the expected counts. The mid-period write deliberately lands inside a period to show that it is held back until the next one.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int DUTY_W   = 8;
  localparam int DEAD_W   = 4;
  localparam int CTRL_W   = DUTY_W + DEAD_W;
  localparam int FIELD_N  = 2;
  localparam int PERIOD   = (1 << DUTY_W) - 1;
  localparam int CNT_LAST = PERIOD - 1;

  typedef struct packed {
    logic [DEAD_W-1:0] dead;
    logic [DUTY_W-1:0] duty;
  } ctrl_t;

  typedef enum logic {
    SRC_REG  = 1'b0,
    SRC_PINS = 1'b1
  } src_e;
endpackage

// File: rtl/cpwm_ctrl_reg.sv
module cpwm_ctrl_reg
  import cpwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [FIELD_N-1:0] wr_field,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic               src_sel,
  input  logic [CTRL_W-1:0]  pin_bits,
  output ctrl_t              ctrl_o
);
  ctrl_t             ctrl_q;
  logic [CTRL_W-1:0] wr_mask;
  logic              wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign wr_mask  = {{DEAD_W{wr_field[1]}}, {DUTY_W{wr_field[0]}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_fire) begin
      ctrl_q <= (ctrl_q & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  assign ctrl_o = (src_e'(src_sel) == SRC_PINS) ? ctrl_t'(pin_bits) : ctrl_q;

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> $stable(ctrl_q)); // R8

  AST_FIELD_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_field[1]) |=> $stable(ctrl_q.dead)); // R8
endmodule

// File: rtl/cpwm_period.sv
module cpwm_period
  import cpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl_i,
  output logic              raw_o,
  output logic [DEAD_W-1:0] dead_o
);
  logic [DUTY_W-1:0] cnt_q;
  ctrl_t             shadow_q;
  logic              wrap;

  assign wrap = (cnt_q == DUTY_W'(CNT_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) shadow_q <= ctrl_i;
    end
  end

  assign raw_o  = (cnt_q < shadow_q.duty);
  assign dead_o = shadow_q.dead;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DUTY_W'(CNT_LAST)); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> $stable(shadow_q)); // R7

  AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
    (shadow_q.duty == '1) |-> raw_o); // R2
endmodule

// File: rtl/cpwm_gate.sv
module cpwm_gate
  import cpwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              want_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic              drv_o
);
  localparam logic [DEAD_W-1:0] RUN_MAX = '1;

  logic [DEAD_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !want_i) begin
      run_q <= '0;
    end else if (run_q != RUN_MAX) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign drv_o = want_i && (run_q >= dead_i) && !rst;
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [FIELD_N-1:0] wr_field,
  input  logic [CTRL_W-1:0]  wr_data,
  input  logic               src_sel,
  input  logic [CTRL_W-1:0]  pin_bits,
  output logic               drv_hi,
  output logic               drv_lo
);
  ctrl_t             ctrl;
  logic              raw;
  logic [DEAD_W-1:0] dead_sh;
  logic [1:0]        want;
  logic [1:0]        drive;

  cpwm_ctrl_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_field (wr_field),
    .wr_data  (wr_data),
    .src_sel  (src_sel),
    .pin_bits (pin_bits),
    .ctrl_o   (ctrl)
  );

  cpwm_period u_period (
    .clk    (clk),
    .rst    (rst),
    .ctrl_i (ctrl),
    .raw_o  (raw),
    .dead_o (dead_sh)
  );

  assign want = {~raw, raw};

  for (genvar s = 0; s < 2; s++) begin : g_side
    cpwm_gate u_gate (
      .clk    (clk),
      .rst    (rst),
      .want_i (want[s]),
      .dead_i (dead_sh),
      .drv_o  (drive[s])
    );
  end

  assign drv_hi = drive[0];
  assign drv_lo = drive[1];

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(drv_hi && drv_lo)); // R5

  AST_HI_GAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(raw) && dead_sh != '0) |-> !drv_hi); // R3

  AST_HI_NOGAP: assert property (@(posedge clk) disable iff (rst)
    ($rose(raw) && dead_sh == '0) |-> drv_hi); // R3

  AST_LO_GAP: assert property (@(posedge clk) disable iff (rst)
    ($fell(raw) && dead_sh != '0) |-> (!drv_lo && !drv_hi)); // R4
endmodule

// File: tb/cpwm_top_tb.sv
module cpwm_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_field = 2'b00;
  logic [11:0] wr_data = '0;
  logic        src_sel = 1'b0;
  logic [11:0] pin_bits = '0;
  logic        drv_hi, drv_lo;

  int n_checks = 0;
  int n_fail   = 0;
  int ph       = 0;

  always #5 clk = ~clk;

  cpwm_top u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_field(wr_field), .wr_data(wr_data), .src_sel(src_sel),
    .pin_bits(pin_bits), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  // Period position from the requirement: 255 cycles, 0 after reset
  always @(posedge clk) ph <= rst ? 0 : ((ph == 254) ? 0 : ph + 1);

  // columns: source, duty, dead, exp hi count, exp lo count, exp first hi (255 = none)
  localparam int VEC_N = 8;
  localparam int VEC [VEC_N][6] = '{
    '{0, 128,  0, 128, 127,   0},
    '{1, 128,  4, 124, 123,   4},
    '{0,  85, 15,  70, 155,  15},
    '{1, 255,  8, 255,   0,   0},
    '{0,   0,  8,   0, 255, 255},
    '{1,   3,  5,   0, 247, 255},
    '{0, 250,  7, 243,   0,   7},
    '{1,   1,  0,   1, 254,   0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] f, input logic [11:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_field = f; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_field = 2'b00;
  endtask

  task automatic measure(output int hi_n, output int lo_n, output int ov_n, output int first);
    hi_n = 0; lo_n = 0; ov_n = 0; first = 255;
    do @(negedge clk); while (ph != 0);
    for (int k = 0; k < 255; k++) begin
      if (k != 0) @(negedge clk);
      #2;
      if (drv_hi) begin hi_n++; if (first == 255) first = k; end
      if (drv_lo) lo_n++;
      if (drv_hi && drv_lo) ov_n++;
    end
  endtask

  task automatic settle(output int hi_n, output int lo_n, output int ov_n, output int first);
    for (int r = 0; r < 3; r++) measure(hi_n, lo_n, ov_n, first);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int h, l, o, f;
    repeat (3) @(negedge clk);
    #2;
    check("R10 reset hi", drv_hi, 0);
    check("R10 reset lo", drv_lo, 0);
    @(negedge clk); rst = 1'b0;
    #2;
    check("R11 ready", wr_ready, 1);
    measure(h, l, o, f);
    check("R10 cleared reg hi", h, 0);
    check("R10 cleared reg lo", l, 255);

    // table-driven steady-state pulses (R1 R2 R3 R4 R5 R6 R9)
    for (int i = 0; i < VEC_N; i++) begin
      if (VEC[i][0] == 0) begin
        @(negedge clk); src_sel = 1'b0;
        reg_write(2'b11, {4'(VEC[i][2]), 8'(VEC[i][1])});
      end else begin
        @(negedge clk);
        pin_bits = {4'(VEC[i][2]), 8'(VEC[i][1])};
        src_sel  = 1'b1;
      end
      settle(h, l, o, f);
      check("R1 R3 hi width", h, VEC[i][3]);
      check("R4 R6 lo width", l, VEC[i][4]);
      check("R5 overlap", o, 0);
      check("R3 hi first", f, VEC[i][5]);
    end

    // R9: register writes ignored while pins are the source
    @(negedge clk); pin_bits = {4'd0, 8'd60}; src_sel = 1'b1;
    reg_write(2'b11, {4'd0, 8'd200});
    settle(h, l, o, f);
    check("R9 pins win", h, 60);

    // R8: partial field writes
    @(negedge clk); src_sel = 1'b0;
    reg_write(2'b11, {4'd10, 8'd100});
    settle(h, l, o, f);
    check("R8 full write", h, 90);
    reg_write(2'b01, {4'd0, 8'd50});
    settle(h, l, o, f);
    check("R8 duty only", h, 40);
    reg_write(2'b10, {4'd2, 8'd255});
    settle(h, l, o, f);
    check("R8 dead only", h, 48);
    reg_write(2'b00, {4'd9, 8'd9});
    settle(h, l, o, f);
    check("R8 no strobe", h, 48);

    // R7: mid-period write does not alter the running period
    reg_write(2'b11, {4'd0, 8'd128});
    settle(h, l, o, f);
    h = 0;
    do @(negedge clk); while (ph != 0);
    for (int k = 0; k < 255; k++) begin
      if (k != 0) @(negedge clk);
      #2;
      if (drv_hi) h++;
      if (k == 100) begin
        wr_valid = 1'b1; wr_field = 2'b11; wr_data = {4'd0, 8'd200};
      end
      if (k == 101) begin
        wr_valid = 1'b0; wr_field = 2'b00;
      end
    end
    check("R7 current period kept", h, 128);
    measure(h, l, o, f);
    check("R7 next period new", h, 200);

    // R10: mid-run reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    check("R10 hi in reset", drv_hi, 0);
    check("R10 lo in reset", drv_lo, 0);
    @(negedge clk); rst = 1'b0;
    measure(h, l, o, f);
    check("R10 reg cleared hi", h, 0);
    check("R10 reg cleared lo", l, 255);

    finish_run();
  end
endmodule